// File: doc/BRIEF.md
# Parallel Video Frame Timing Generator

This block turns a row-by-row pixel stream into the parallel output of a progressive-scan camera. It drives a 12-bit data bus, a frame-valid and a line-valid qualifier, and a pixel clock. One frame is a run of rows, and each row is a burst of line-valid clocks. Horizontal blanking separates the rows. Vertical blanking separates the frames. Frame-valid opens a fixed number of clocks before the first row of a frame and closes the same number of clocks after the last row.

Two optional groups of metadata rows can frame the image rows. A register-data group comes directly before the first image row and a statistics group directly after the last one. Each metadata row carries a fixed marker pattern. Image rows come from an external stream or from an internal test pattern. The stream is pulled one word per clock through a read strobe.

Geometry and blanking are programmable. They are taken only at reset and at the start of a frame, so reprogramming never cuts a frame short. The output is silent after reset. It is driven only while a parallel-enable bit is set and the active-low output enable is held low.

Top module: `pvid_timing`

## Requirements
- R1: Frame-valid is high for exactly 6 clocks, with line-valid low, before the first line-valid clock of every frame.
- R2: After the last line-valid clock of a frame, frame-valid stays high for exactly 6 clocks with line-valid low, then falls.
- R3: Every row holds line-valid high for exactly `cfg_cols_i` clocks. Consecutive rows of a frame are separated by exactly `cfg_hblank_i` clocks with line-valid low and frame-valid high. A frame has `cfg_rows_i` image rows plus 2 per enabled metadata group. Line-valid is never high while frame-valid is low.
- R4: The number of clocks from the last line-valid clock of a frame to the first line-valid clock of the next frame equals `cfg_vblank_i`.
- R5: When `cfg_emb_en_i` is set, 2 register-data rows precede the image rows. Word at column c of register-data row k (k = 0, 1) is {2'b10, k[0], c[8:0]}.
- R6: When `cfg_stat_en_i` is set, 2 statistics rows follow the image rows. Word at column c of statistics row k is {2'b11, k[0], c[8:0]}.
- R7: With `cfg_test_en_i` low, `pix_rd_o` is high exactly in the clocks that produce an image-row word. The word presented on `pix_i` in such a clock appears on `dat_o` one clock later. `pix_rd_o` is low in every other clock.
- R8: With `cfg_test_en_i` high, the word at column c of image row a (counting from 0) is {a[5:0], c[5:0]}, and `pix_rd_o` stays low.
- R9: `fv_o`, `lv_o` and `dat_o` change only on a falling edge of `pix_clk_o`. While driven, `pix_clk_o` is the inverse of `clk`. While not driven, it is held low.
- R10: After reset `fv_o`, `lv_o`, `dat_o`, `drv_en_o` and `pix_clk_o` are 0. They stay 0 from the clock after `par_en_i` is low or `oe_n_i` is high. The timing keeps running underneath, so re-enabling mid-frame resumes the frame in progress.
- R11: Configuration inputs take effect only at the start of a frame. A frame in progress keeps its row width and row count when the inputs change.
- R12: A column or row count of 0 is treated as 1. A horizontal blanking below 1 is treated as 1. A vertical blanking below 13 is treated as 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en_i | input | 1 | Parallel output enable bit (0 after reset) |
| oe_n_i | input | 1 | Active-low output enable |
| cfg_cols_i | input | 12 | Image columns per row |
| cfg_rows_i | input | 12 | Image rows per frame |
| cfg_hblank_i | input | 12 | Clocks between rows |
| cfg_vblank_i | input | 16 | Clocks between frames, from last to first line-valid |
| cfg_emb_en_i | input | 1 | Enable the register-data rows |
| cfg_stat_en_i | input | 1 | Enable the statistics rows |
| cfg_test_en_i | input | 1 | Select the internal test pattern for image rows |
| pix_i | input | 12 | Streamed image word |
| pix_rd_o | output | 1 | Image word taken from `pix_i` in this clock |
| pix_clk_o | output | 1 | Pixel clock; data is captured on its rising edge |
| fv_o | output | 1 | Frame valid |
| lv_o | output | 1 | Line valid |
| dat_o | output | 12 | Pixel data |
| drv_en_o | output | 1 | High while the pads should drive (low models high impedance) |

## Verification
Two things can land in the same clock: a configuration write and a running frame that must finish on its old geometry. The test provokes this by rewriting width, height and blanking one clock after the first line-valid clock of a frame. It then counts that frame's line width and row count against the old settings, and the next frame's against the new ones. The output enable can also drop in the middle of a line. The test does this and expects the bus to go quiet on the next clock, then expects frame-valid high again right after re-enabling, since the frame went on underneath. A sweep over small widths, heights, gaps and both metadata groups checks every word, lead, lag and blanking count arithmetically.

// File: rtl/pvid_pkg.sv
package pvid_pkg;

    localparam int DATA_W    = 12;
    localparam int COL_W     = 12;
    localparam int ROW_W     = 12;
    localparam int VB_W      = 16;
    localparam int CNT_W     = VB_W;
    localparam int TROW_W    = ROW_W + 2;
    localparam int EDGE_CLKS = 6;
    localparam int META_ROWS = 2;
    localparam int HB_MIN    = 1;
    localparam int VB_MIN    = 2 * EDGE_CLKS + 1;

    typedef struct packed {
        logic [COL_W-1:0] cols;
        logic [ROW_W-1:0] rows;
        logic [COL_W-1:0] hblank;
        logic [VB_W-1:0]  vblank;
        logic             emb_en;
        logic             stat_en;
        logic             test_en;
    } pvid_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LEAD = 3'd1,
        PH_LINE = 3'd2,
        PH_HGAP = 3'd3,
        PH_TAIL = 3'd4
    } pvid_phase_e;

    typedef enum logic [1:0] {
        RK_EMB  = 2'd0,
        RK_IMG  = 2'd1,
        RK_STAT = 2'd2
    } pvid_row_e;

    typedef struct packed {
        logic              fv;
        logic              lv;
        logic [DATA_W-1:0] dat;
    } pvid_beat_t;

    function automatic pvid_cfg_t clamp_cfg(pvid_cfg_t c);
        pvid_cfg_t r;
        r = c;
        if (c.cols == '0)                   r.cols   = COL_W'(1);
        if (c.rows == '0)                   r.rows   = ROW_W'(1);
        if (c.hblank < COL_W'(HB_MIN))      r.hblank = COL_W'(HB_MIN);
        if (c.vblank < VB_W'(VB_MIN))       r.vblank = VB_W'(VB_MIN);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] meta_word(logic is_stat, logic idx,
                                                    logic [COL_W-1:0] col);
        return {1'b1, is_stat, idx, col[8:0]};
    endfunction

    function automatic logic [DATA_W-1:0] test_word(logic [TROW_W-1:0] arow,
                                                    logic [COL_W-1:0] col);
        return {arow[5:0], col[5:0]};
    endfunction

endpackage

// File: rtl/pvid_cfg.sv
module pvid_cfg
    import pvid_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  pvid_cfg_t cfg_i,
    output pvid_cfg_t cfg_o
);

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            cfg_o <= clamp_cfg(cfg_i);
        end
    end

    // R12: held geometry never carries a value below its floor
    assert_clamp_R12: assert property (@(posedge clk) disable iff (rst)
        (cfg_o.cols != '0) && (cfg_o.rows != '0) &&
        (cfg_o.hblank >= COL_W'(HB_MIN)) && (cfg_o.vblank >= VB_W'(VB_MIN)));

endmodule

// File: rtl/pvid_seq.sv
module pvid_seq
    import pvid_pkg::*;
#(
    parameter int EDGE = EDGE_CLKS,
    parameter int META = META_ROWS
)(
    input  logic               clk,
    input  logic               rst,
    input  pvid_cfg_t          cfg_i,
    output pvid_phase_e        phase_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [TROW_W-1:0]  row_o,
    output logic               start_o
);

    localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(EDGE - 1);

    logic [TROW_W-1:0] rows_total;
    logic [TROW_W-1:0] row_last;
    logic [CNT_W-1:0]  col_last;
    logic [CNT_W-1:0]  gap_last;
    logic [CNT_W-1:0]  idle_last;

    always_comb begin
        rows_total = TROW_W'(cfg_i.rows)
                   + (cfg_i.emb_en  ? TROW_W'(META) : '0)
                   + (cfg_i.stat_en ? TROW_W'(META) : '0);
        row_last   = rows_total - TROW_W'(1);
        col_last   = CNT_W'(cfg_i.cols) - CNT_W'(1);
        gap_last   = CNT_W'(cfg_i.hblank) - CNT_W'(1);
        idle_last  = CNT_W'(cfg_i.vblank) - CNT_W'(2 * EDGE + 1);
    end

    assign start_o = (phase_o == PH_IDLE) && (cnt_o == idle_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_IDLE;
            cnt_o   <= '0;
            row_o   <= '0;
        end else begin
            case (phase_o)
                PH_IDLE: begin
                    if (cnt_o == idle_last) begin
                        phase_o <= PH_LEAD;
                        cnt_o   <= '0;
                    end else begin
                        cnt_o   <= cnt_o + CNT_W'(1);
                    end
                end
                PH_LEAD: begin
                    if (cnt_o == EDGE_LAST) begin
                        phase_o <= PH_LINE;
                        cnt_o   <= '0;
                        row_o   <= '0;
                    end else begin
                        cnt_o   <= cnt_o + CNT_W'(1);
                    end
                end
                PH_LINE: begin
                    if (cnt_o == col_last) begin
                        phase_o <= (row_o == row_last) ? PH_TAIL : PH_HGAP;
                        cnt_o   <= '0;
                    end else begin
                        cnt_o   <= cnt_o + CNT_W'(1);
                    end
                end
                PH_HGAP: begin
                    if (cnt_o == gap_last) begin
                        phase_o <= PH_LINE;
                        cnt_o   <= '0;
                        row_o   <= row_o + TROW_W'(1);
                    end else begin
                        cnt_o   <= cnt_o + CNT_W'(1);
                    end
                end
                PH_TAIL: begin
                    if (cnt_o == EDGE_LAST) begin
                        phase_o <= PH_IDLE;
                        cnt_o   <= '0;
                    end else begin
                        cnt_o   <= cnt_o + CNT_W'(1);
                    end
                end
                default: begin
                    phase_o <= PH_IDLE;
                    cnt_o   <= '0;
                end
            endcase
        end
    end

    // R1: the lead window ends after exactly EDGE clocks and opens a row
    assert_lead_len_R1: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_LEAD && cnt_o == EDGE_LAST) |=> (phase_o == PH_LINE && cnt_o == '0));

    // R2: the lag window ends after exactly EDGE clocks
    assert_lag_len_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_TAIL && cnt_o == EDGE_LAST) |=> (phase_o == PH_IDLE));

    // R3: the lag window only follows a row that is the last of the frame
    assert_tail_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_o == PH_TAIL) |-> ($past(row_o) == row_last));

endmodule

// File: rtl/pvid_beat.sv
module pvid_beat
    import pvid_pkg::*;
#(
    parameter int META = META_ROWS
)(
    input  pvid_phase_e        phase_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [TROW_W-1:0]  row_i,
    input  pvid_cfg_t          cfg_i,
    input  logic [DATA_W-1:0]  pix_i,
    output pvid_beat_t         beat_o,
    output logic               rd_o
);

    logic [TROW_W-1:0] pre_rows;
    logic [TROW_W-1:0] img_end;
    logic [TROW_W-1:0] img_row;
    logic [TROW_W-1:0] stat_row;
    logic [COL_W-1:0]  col;
    pvid_row_e         kind;
    logic              in_line;

    always_comb begin
        pre_rows = cfg_i.emb_en ? TROW_W'(META) : '0;
        img_end  = pre_rows + TROW_W'(cfg_i.rows);
        img_row  = row_i - pre_rows;
        stat_row = row_i - img_end;
        col      = cnt_i[COL_W-1:0];
        in_line  = (phase_i == PH_LINE);

        if (row_i < pre_rows)     kind = RK_EMB;
        else if (row_i < img_end) kind = RK_IMG;
        else                      kind = RK_STAT;

        beat_o.fv  = (phase_i == PH_LEAD) || (phase_i == PH_LINE) ||
                     (phase_i == PH_HGAP) || (phase_i == PH_TAIL);
        beat_o.lv  = in_line;
        beat_o.dat = '0;
        rd_o       = 1'b0;

        if (in_line) begin
            case (kind)
                RK_EMB:  beat_o.dat = meta_word(1'b0, row_i[0], col);
                RK_STAT: beat_o.dat = meta_word(1'b1, stat_row[0], col);
                default: begin
                    if (cfg_i.test_en) begin
                        beat_o.dat = test_word(img_row, col);
                    end else begin
                        beat_o.dat = pix_i;
                        rd_o       = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pvid_timing.sv
module pvid_timing
    import pvid_pkg::*;
#(
    parameter int EDGE = EDGE_CLKS,
    parameter int META = META_ROWS
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              par_en_i,
    input  logic              oe_n_i,
    input  logic [COL_W-1:0]  cfg_cols_i,
    input  logic [ROW_W-1:0]  cfg_rows_i,
    input  logic [COL_W-1:0]  cfg_hblank_i,
    input  logic [VB_W-1:0]   cfg_vblank_i,
    input  logic              cfg_emb_en_i,
    input  logic              cfg_stat_en_i,
    input  logic              cfg_test_en_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic              pix_rd_o,
    output logic              pix_clk_o,
    output logic              fv_o,
    output logic              lv_o,
    output logic [DATA_W-1:0] dat_o,
    output logic              drv_en_o
);

    pvid_cfg_t         cfg_in;
    pvid_cfg_t         cfg_q;
    pvid_phase_e       phase;
    logic [CNT_W-1:0]  cnt;
    logic [TROW_W-1:0] row;
    logic              frame_start;
    pvid_beat_t        beat_d;
    pvid_beat_t        beat_q;
    logic              drv_d;
    logic              drv_q;

    always_comb begin
        cfg_in.cols    = cfg_cols_i;
        cfg_in.rows    = cfg_rows_i;
        cfg_in.hblank  = cfg_hblank_i;
        cfg_in.vblank  = cfg_vblank_i;
        cfg_in.emb_en  = cfg_emb_en_i;
        cfg_in.stat_en = cfg_stat_en_i;
        cfg_in.test_en = cfg_test_en_i;
    end

    pvid_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (frame_start),
        .cfg_i  (cfg_in),
        .cfg_o  (cfg_q)
    );

    pvid_seq #(.EDGE(EDGE), .META(META)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg_q),
        .phase_o (phase),
        .cnt_o   (cnt),
        .row_o   (row),
        .start_o (frame_start)
    );

    pvid_beat #(.META(META)) u_beat (
        .phase_i (phase),
        .cnt_i   (cnt),
        .row_i   (row),
        .cfg_i   (cfg_q),
        .pix_i   (pix_i),
        .beat_o  (beat_d),
        .rd_o    (pix_rd_o)
    );

    assign drv_d = par_en_i & ~oe_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            drv_q  <= 1'b0;
        end else begin
            beat_q <= drv_d ? beat_d : '0;
            drv_q  <= drv_d;
        end
    end

    assign fv_o      = beat_q.fv;
    assign lv_o      = beat_q.lv;
    assign dat_o     = beat_q.dat;
    assign drv_en_o  = drv_q;
    assign pix_clk_o = drv_q & ~clk;

    // R3: a line never appears outside its frame
    assert_lv_in_fv_R3: assert property (@(posedge clk) disable iff (rst)
        lv_o |-> fv_o);

    // R10: disabled or not output-enabled means a silent bus on the next clock
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (oe_n_i || !par_en_i) |=> (!fv_o && !lv_o && dat_o == '0 && !drv_en_o));

    // R11: held configuration only moves on a frame start
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg_q));

    // R7: every stream read shows up as a line-valid word when driven
    assert_read_to_line_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_rd_o && drv_d) |=> lv_o);

endmodule

// File: tb/pvid_timing_tb_top.sv
`timescale 1ns/100ps
module pvid_timing_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        par_en = 1'b0;
    logic        oe_n = 1'b0;
    logic [11:0] cols = 12'd4;
    logic [11:0] rows = 12'd2;
    logic [11:0] hb = 12'd2;
    logic [15:0] vb = 16'd14;
    logic        emb = 1'b0;
    logic        stat = 1'b0;
    logic        tst = 1'b0;
    logic [11:0] pix = 12'd0;
    logic        pix_rd, pclk, fv, lv, drv;
    logic [11:0] dat;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic        s_fv = 0, s_lv = 0, s_rd = 0, s_drv = 0, s_pclk = 0, prev_rd = 0;
    logic [11:0] s_d = 0, last_pix = 0;

    always #2.5 clk = ~clk;

    pvid_timing dut_i (
        .clk(clk), .rst(rst), .par_en_i(par_en), .oe_n_i(oe_n),
        .cfg_cols_i(cols), .cfg_rows_i(rows), .cfg_hblank_i(hb), .cfg_vblank_i(vb),
        .cfg_emb_en_i(emb), .cfg_stat_en_i(stat), .cfg_test_en_i(tst),
        .pix_i(pix), .pix_rd_o(pix_rd), .pix_clk_o(pclk),
        .fv_o(fv), .lv_o(lv), .dat_o(dat), .drv_en_o(drv)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one clock: sample at the rising pixel-clock edge, recheck before the next fall
    task automatic tick();
        @(negedge clk);
        prev_rd  = s_rd;
        last_pix = pix;
        s_fv = fv; s_lv = lv; s_d = dat; s_rd = pix_rd; s_drv = drv; s_pclk = pclk;
        chk(s_pclk == s_drv, "R9 pixel clock high at sample when driven", s_pclk, s_drv);
        #1.5;
        chk({fv, lv, dat} == {s_fv, s_lv, s_d}, "R9 outputs stable while pixel clock high",
            {fv, lv, dat}, {s_fv, s_lv, s_d});
        cyc++;
        pix = 12'((cyc * 13 + 7) & 12'hfff);
    endtask

    function automatic logic [11:0] exp_word(int r, int c, int h, bit e, bit s, bit t,
                                             logic [11:0] lp);
        int pre;
        pre = e ? 2 : 0;
        if (r < pre)          return {2'b10, 1'(r & 1), 9'(c)};
        else if (r < pre + h) return t ? {6'(r - pre), 6'(c)} : lp;
        else                  return {2'b11, 1'((r - pre - h) & 1), 9'(c)};
    endfunction

    task automatic wait_fv(input bit v);
        while (s_fv != v) tick();
    endtask

    // measures one full frame after the current one, plus the gap to the next frame
    task automatic check_frame(input int w, input int h, input int g, input int v,
                               input bit e, input bit s, input bit t);
        int lead, nrows, pre, hi, lo, tail, gap, wbad;
        pre = e ? 2 : 0;
        nrows = h + pre + (s ? 2 : 0);
        tick();
        wait_fv(0);
        wait_fv(1);
        lead = 1;
        tick();
        while (!s_lv && s_fv) begin lead++; tick(); end
        chk(lead == 6, "R1 frame-valid lead", lead, 6);
        for (int r = 0; r < nrows; r++) begin
            hi = 0; wbad = 0;
            while (s_lv) begin
                logic [11:0] ew;
                bit img_stream;
                ew = exp_word(r, hi, h, e, s, t, last_pix);
                img_stream = (r >= pre) && (r < pre + h) && !t;
                if (s_d != ew) begin
                    wbad++;
                    if (r < pre)          chk(0, "R5 register-data row word", s_d, ew);
                    else if (r < pre + h) chk(0, t ? "R8 test pattern word" : "R7 stream word", s_d, ew);
                    else                  chk(0, "R6 statistics row word", s_d, ew);
                end
                if (prev_rd != img_stream) begin
                    wbad++;
                    chk(0, "R7 read strobe placement", prev_rd, img_stream);
                end
                hi++;
                tick();
            end
            if (r < pre)          chk(wbad == 0, "R5 register-data row", wbad, 0);
            else if (r < pre + h) chk(wbad == 0, t ? "R8 image row" : "R7 image row", wbad, 0);
            else                  chk(wbad == 0, "R6 statistics row", wbad, 0);
            chk(hi == w, "R3 line width", hi, w);
            if (r < nrows - 1) begin
                lo = 0;
                while (!s_lv && s_fv) begin lo++; tick(); end
                chk(lo == g && s_fv, "R3 row gap inside frame", lo, g);
            end else begin
                tail = 0;
                while (s_fv && !s_lv) begin tail++; tick(); end
                chk(tail == 6 && !s_fv, "R2 frame-valid lag", tail, 6);
                gap = tail;
                while (!s_lv) begin gap++; tick(); end
                chk(gap == v, "R4 vertical blanking", gap, v);
            end
        end
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=0 (run did not end)", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int zeros;
        for (int i = 0; i < 4; i++) tick();
        chk({fv, lv, dat, drv, pclk} == '0, "R10 reset state", {fv, lv, dat, drv, pclk}, 0);
        rst = 1'b0;
        // R10: timing runs but parallel enable is still off
        zeros = 0;
        for (int i = 0; i < 80; i++) begin
            tick();
            if ({s_fv, s_lv, s_d, s_drv, s_pclk} != '0) zeros++;
        end
        chk(zeros == 0, "R10 silent while parallel enable low", zeros, 0);
        par_en = 1'b1;

        // near-exhaustive sweep of small geometries
        for (int t = 0; t < 2; t++)
        for (int md = 0; md < 4; md++)
        for (int w = 1; w <= 3; w++)
        for (int h = 1; h <= 2; h++)
        for (int g = 1; g <= 2; g++) begin
            int v;
            v = 13 + ((w + h + md) % 3);
            cols = 12'(w); rows = 12'(h); hb = 12'(g); vb = 16'(v);
            emb = md[0]; stat = md[1]; tst = t[0];
            check_frame(w, h, g, v, md[0], md[1], t[0]);
        end

        // R12: floors on degenerate settings
        cols = 0; rows = 2; hb = 0; vb = 3; emb = 0; stat = 0; tst = 1;
        check_frame(1, 2, 1, 13, 0, 0, 1);

        // R11: reprogram right after the first line-valid clock of a frame
        cols = 3; rows = 2; hb = 2; vb = 14; emb = 1; stat = 0; tst = 0;
        check_frame(3, 2, 2, 14, 1, 0, 0);
        cols = 5; rows = 1; hb = 1; vb = 20; emb = 0; stat = 1; tst = 1;
        begin
            int hi, nl;
            bit plv;
            hi = 0;
            while (s_lv) begin hi++; tick(); end
            chk(hi == 3, "R11 running frame keeps old width", hi, 3);
            nl = 1; plv = 0;
            while (s_fv) begin
                if (s_lv && !plv) nl++;
                plv = s_lv;
                tick();
            end
            chk(nl == 4, "R11 running frame keeps old row count", nl, 4);
        end
        check_frame(5, 1, 1, 20, 0, 1, 1);

        // R10: output enable dropped inside a line, then restored
        cols = 4; rows = 3; hb = 2; vb = 14; emb = 0; stat = 0; tst = 1;
        check_frame(4, 3, 2, 14, 0, 0, 1);
        oe_n = 1'b1;
        tick();
        chk({s_fv, s_lv, s_d, s_drv, s_pclk} == '0, "R10 output enable high forces zero",
            {s_fv, s_lv, s_d, s_drv, s_pclk}, 0);
        oe_n = 1'b0;
        tick();
        chk(s_drv && s_fv, "R10 frame resumes after re-enable", {s_drv, s_fv}, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule